// File: doc/BRIEF.md
# Predicated Word-Load Execution Unit

This unit executes one word-load instruction at a time for a 32-bit core. On a start pulse it takes the instruction word, the current N/Z/C/V flags and the values already read from the base and offset registers. It decodes six addressing variants: an immediate or a register offset, each used plainly, with pre-indexed base update, or with post-indexed base update. It tests the 4-bit predicate against the flags and forms the effective address. It then makes one word read through a request/response memory port.

On completion the unit raises `done` for one cycle. In that cycle it presents at most two register writes: the loaded word to the destination, and the updated address to the base register. Instead of the writes it can report a memory fault or an illegal opcode. The flags are only read. The register file, flag generation, stores and narrow loads live outside this block.

Top module: `cond_load_unit`

## Requirements
- R1: Opcode `instrI[6:0]` selects the variant: 1 immediate plain, 2 immediate pre-indexed, 3 immediate post-indexed, 4 register plain, 5 register pre-indexed, 6 register post-indexed. Any other opcode raises `illegal` in the `done` cycle, with no memory request, no register write and no fault. The opcode is checked before the predicate.
- R2: The predicate `instrI[10:7]` is tested against `flagsI` = {N,Z,C,V} (bit 3 = N, bit 0 = V). The codes are: 0 always; 1 Z; 2 !Z; 3 C; 4 !C; 5 N; 6 !N; 7 V; 8 !V; 9 C&!Z; 10 !C|Z; 11 N==V; 12 N!=V; 13 !Z&(N==V); 14 Z|(N!=V); 15 never.
- R3: When the predicate fails, `done` rises in the cycle after the start edge and lasts one cycle. There is no memory request, no write, no fault and no illegal flag.
- R4: In immediate forms the offset is `instrI[31:21]`, sign-extended and multiplied by 4, which gives -4096 to 4092.
- R5: In register forms the offset is `offValI`. The index of the offset register sits in `instrI[25:21]`, and the caller supplies its value.
- R6: Plain forms read at base+offset. They write the loaded word to register `instrI[15:11]` and make no base write.
- R7: Pre-indexed forms read at base+offset. They also write base+offset to register `instrI[20:16]`.
- R8: Post-indexed forms read at the unmodified base. They also write base+offset to the base register.
- R9: `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is sampled high. `done` follows in the cycle after the edge at which `memRspValid` is accepted.
- R10: An effective address whose two low bits are not zero raises `memFault` without a memory request and without any register write.
- R11: A response with `memRspErr` set raises `memFault` and suppresses both register writes.
- R12: When the destination and base indices are equal in a write-back form, only the destination write (the loaded word) is presented.
- R13: After reset the unit is idle: `done`, `memReqValid`, both write enables, `memFault` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start pulse; taken only while idle |
| instrI | input | 32 | Instruction word |
| flagsI | input | 4 | Flags {N,Z,C,V} |
| baseValI | input | 32 | Value of the base register |
| offValI | input | 32 | Value of the offset register (register forms) |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | 32 | Read address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| memRspErr | input | 1 | Read failed |
| done | output | 1 | Instruction complete (one cycle) |
| dstWrEn | output | 1 | Destination write enable |
| dstWrIdx | output | 5 | Destination register index |
| dstWrData | output | 32 | Loaded word |
| baseWrEn | output | 1 | Base write enable |
| baseWrIdx | output | 5 | Base register index |
| baseWrData | output | 32 | Updated base value |
| memFault | output | 1 | Memory fault (misaligned or failed read) |
| illegal | output | 1 | Unknown opcode |

## Verification
A vector table runs each of the six opcodes with differing base values, positive and negative offsets and ready delays of zero to three cycles. The read address and the base write value tell pre-indexed apart from post-indexed, and plain from write-back. Extreme immediates check sign extension and scaling. Dedicated vectors cover misalignment in the immediate, register and post-indexed forms, an error response, two illegal opcodes and matching destination and base indices. A sweep of all sixteen predicate codes against four flag patterns shows whether each code reads the right flag and the right polarity.

// File: rtl/cld_pkg.sv
package cld_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned IMM_W = 11;

  typedef enum logic [1:0] {OC_RUN, OC_SKIP, OC_ILL, OC_MIS} outcome_t;
  typedef enum logic [1:0] {WB_NONE, WB_PRE, WB_POST} wbMode_t;

  typedef struct packed {
    logic takeOp;
    logic takeRsp;
  } strobe_t;

  function automatic logic predOk(input logic [3:0] code, input logic [3:0] fl);
    logic n, z, c, v;
    {n, z, c, v} = fl;
    case (code)
      4'd0:    predOk = 1'b1;
      4'd1:    predOk = z;
      4'd2:    predOk = !z;
      4'd3:    predOk = c;
      4'd4:    predOk = !c;
      4'd5:    predOk = n;
      4'd6:    predOk = !n;
      4'd7:    predOk = v;
      4'd8:    predOk = !v;
      4'd9:    predOk = c && !z;
      4'd10:   predOk = !c || z;
      4'd11:   predOk = (n == v);
      4'd12:   predOk = (n != v);
      4'd13:   predOk = !z && (n == v);
      4'd14:   predOk = z || (n != v);
      default: predOk = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cld_dpath.sv
module cld_dpath
  import cld_pkg::*;
#(
  parameter int unsigned W    = XLEN,
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned IMMW = IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [31:0]   instrI,
  input  logic [3:0]    flagsI,
  input  logic [W-1:0]  baseValI,
  input  logic [W-1:0]  offValI,
  input  logic [W-1:0]  rspData,
  input  logic          rspErr,
  output outcome_t      outcomeNext,
  output logic [W-1:0]  addrQ,
  output logic [W-1:0]  newBaseQ,
  output logic [W-1:0]  dataQ,
  output logic          errQ,
  output logic          baseWrOk,
  output logic [IW-1:0] dstIdxQ,
  output logic [IW-1:0] baseIdxQ
);
  localparam int unsigned IMM_LO  = 21;
  localparam int unsigned DST_LO  = 11;
  localparam int unsigned BASE_LO = DST_LO + IW;
  localparam int unsigned EXT_W   = W - IMMW - 2;

  logic [6:0]      opcode;
  logic [3:0]      pred;
  logic [IMMW-1:0] immField;
  logic            legal, useReg;
  wbMode_t         mode;
  logic [W-1:0]    offset, sum, effAddr;
  logic            wbQ;

  assign opcode   = instrI[6:0];
  assign pred     = instrI[10:7];
  assign immField = instrI[IMM_LO +: IMMW];

  always_comb begin
    legal  = 1'b1;
    useReg = 1'b0;
    mode   = WB_NONE;
    case (opcode)
      7'd1: mode = WB_NONE;
      7'd2: mode = WB_PRE;
      7'd3: mode = WB_POST;
      7'd4: begin useReg = 1'b1; mode = WB_NONE; end
      7'd5: begin useReg = 1'b1; mode = WB_PRE;  end
      7'd6: begin useReg = 1'b1; mode = WB_POST; end
      default: legal = 1'b0;
    endcase
  end

  assign offset  = useReg ? offValI : {{EXT_W{immField[IMMW-1]}}, immField, 2'b00};
  assign sum     = baseValI + offset;
  assign effAddr = (mode == WB_POST) ? baseValI : sum;

  always_comb begin
    if (!legal)                   outcomeNext = OC_ILL;
    else if (!predOk(pred, flagsI)) outcomeNext = OC_SKIP;
    else if (effAddr[1:0] != 2'b00) outcomeNext = OC_MIS;
    else                          outcomeNext = OC_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      newBaseQ <= '0;
      dstIdxQ  <= '0;
      baseIdxQ <= '0;
      wbQ      <= 1'b0;
      dataQ    <= '0;
      errQ     <= 1'b0;
    end else begin
      if (stb.takeOp) begin
        addrQ    <= effAddr;
        newBaseQ <= sum;
        dstIdxQ  <= instrI[DST_LO +: IW];
        baseIdxQ <= instrI[BASE_LO +: IW];
        wbQ      <= (mode != WB_NONE);
        errQ     <= 1'b0;
      end
      if (stb.takeRsp) begin
        dataQ <= rspData;
        errQ  <= rspErr;
      end
    end
  end

  // destination write takes priority over base update on the same index
  assign baseWrOk = wbQ && (baseIdxQ != dstIdxQ);

  p_aligned_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeOp && outcomeNext == OC_RUN) |=> (addrQ[1:0] == 2'b00));
endmodule

// File: rtl/cld_ctrl.sv
module cld_ctrl
  import cld_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startI,
  input  outcome_t outcomeNext,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     errQ,
  input  logic     baseWrOk,
  output strobe_t  stb,
  output logic     memReqValid,
  output logic     done,
  output logic     dstWrEn,
  output logic     baseWrEn,
  output logic     memFault,
  output logic     illegal
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WAIT, S_DONE} state_t;

  state_t   state, stateNext;
  outcome_t outcomeQ;

  always_comb begin
    stateNext   = state;
    stb.takeOp  = 1'b0;
    stb.takeRsp = 1'b0;
    case (state)
      S_IDLE: if (startI) begin
        stb.takeOp = 1'b1;
        stateNext  = (outcomeNext == OC_RUN) ? S_ADDR : S_DONE;
      end
      S_ADDR: if (memReqReady) stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        stb.takeRsp = 1'b1;
        stateNext   = S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      outcomeQ <= OC_SKIP;
    end else begin
      state <= stateNext;
      if (stb.takeOp) outcomeQ <= outcomeNext;
    end
  end

  logic okLoad;
  assign memReqValid = (state == S_ADDR);
  assign done        = (state == S_DONE);
  assign okLoad      = done && (outcomeQ == OC_RUN) && !errQ;
  assign dstWrEn     = okLoad;
  assign baseWrEn    = okLoad && baseWrOk;
  assign memFault    = done && ((outcomeQ == OC_MIS) || (outcomeQ == OC_RUN && errQ));
  assign illegal     = done && (outcomeQ == OC_ILL);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    memFault |-> (!dstWrEn && !baseWrEn));
  p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!memFault && !dstWrEn && !baseWrEn));
  p_rsp_to_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && memRspValid) |=> done);
endmodule

// File: rtl/cond_load_unit.sv
module cond_load_unit
  import cld_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic [31:0] instrI,
  input  logic [3:0]  flagsI,
  input  logic [31:0] baseValI,
  input  logic [31:0] offValI,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        memRspErr,
  output logic        done,
  output logic        dstWrEn,
  output logic [4:0]  dstWrIdx,
  output logic [31:0] dstWrData,
  output logic        baseWrEn,
  output logic [4:0]  baseWrIdx,
  output logic [31:0] baseWrData,
  output logic        memFault,
  output logic        illegal
);
  strobe_t  stb;
  outcome_t outcomeNext;
  logic     errQ, baseWrOk;

  cld_dpath #(.W(XLEN), .IW(IDX_W), .IMMW(IMM_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .instrI     (instrI),
    .flagsI     (flagsI),
    .baseValI   (baseValI),
    .offValI    (offValI),
    .rspData    (memRspData),
    .rspErr     (memRspErr),
    .outcomeNext(outcomeNext),
    .addrQ      (memReqAddr),
    .newBaseQ   (baseWrData),
    .dataQ      (dstWrData),
    .errQ       (errQ),
    .baseWrOk   (baseWrOk),
    .dstIdxQ    (dstWrIdx),
    .baseIdxQ   (baseWrIdx)
  );

  cld_ctrl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .outcomeNext(outcomeNext),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .errQ       (errQ),
    .baseWrOk   (baseWrOk),
    .stb        (stb),
    .memReqValid(memReqValid),
    .done       (done),
    .dstWrEn    (dstWrEn),
    .baseWrEn   (baseWrEn),
    .memFault   (memFault),
    .illegal    (illegal)
  );

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
  p_same_index_r12: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && dstWrEn) |-> (baseWrIdx != dstWrIdx));
endmodule

// File: tb/sim_cond_load_unit.sv
module sim_cond_load_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [31:0] instrI = '0;
  logic [3:0]  flagsI = '0;
  logic [31:0] baseValI = '0, offValI = '0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done, dstWrEn, baseWrEn, memFault, illegal;
  logic [4:0]  dstWrIdx, baseWrIdx;
  logic [31:0] dstWrData, baseWrData;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cond_load_unit u0 (.*);

  function automatic logic [103:0] mkv(input int op, input int cnd, input int rd, input int rs,
      input int f11, input logic [3:0] fl, input logic [31:0] base, input logic [31:0] off, input int lag);
    logic [31:0] ins;
    ins = {f11[10:0], rs[4:0], rd[4:0], cnd[3:0], op[6:0]};
    return {ins, fl, base, off, lag[3:0]};
  endfunction

  localparam int NV = 16;
  localparam logic [103:0] VEC [NV] = '{
    mkv(1, 0, 3, 4, 2, 4'b0000, 32'h1000, 32'h0, 0),            // R6 R4 plain imm
    mkv(2, 1, 6, 7, 1, 4'b0100, 32'h2000, 32'h0, 1),            // R7 pre imm
    mkv(3, 0, 8, 9, 11'h7FF, 4'b0000, 32'h3000, 32'h0, 2),      // R8 post imm, -4
    mkv(4, 0, 1, 2, 3, 4'b0000, 32'h100, 32'h10, 0),            // R5 R6 plain reg
    mkv(5, 11, 10, 11, 4, 4'b1001, 32'h800, 32'hFFFF_FFF0, 3),  // R7 pre reg, negative
    mkv(6, 3, 12, 13, 5, 4'b0010, 32'h4000, 32'h40, 0),         // R8 post reg
    mkv(1, 1, 3, 4, 0, 4'b0000, 32'h1000, 32'h0, 0),            // R3 predicate false
    mkv(1, 15, 3, 4, 0, 4'b1111, 32'h1000, 32'h0, 0),           // R3 never
    mkv(7, 0, 3, 4, 0, 4'b0000, 32'h1000, 32'h0, 0),            // R1 illegal
    mkv(0, 15, 3, 4, 0, 4'b0000, 32'h1000, 32'h0, 0),           // R1 illegal ahead of predicate
    mkv(4, 0, 3, 4, 0, 4'b0000, 32'h1000, 32'h2, 0),            // R10 misaligned reg
    mkv(1, 0, 3, 4, 0, 4'b0000, 32'hE000_0000, 32'h0, 1),       // R11 error response
    mkv(2, 0, 5, 5, 1, 4'b0000, 32'h6000, 32'h0, 0),            // R12 same index
    mkv(1, 0, 2, 3, 11'h400, 4'b0000, 32'h5000, 32'h0, 0),      // R4 min offset
    mkv(2, 0, 2, 3, 11'h3FF, 4'b0000, 32'h5000, 32'h0, 0),      // R4 max offset
    mkv(3, 0, 2, 3, 1, 4'b0000, 32'h7002, 32'h0, 0)             // R10 post uses old base
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit refPred(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return 1; 1: return z; 2: return !z; 3: return cy; 4: return !cy;
      5: return n; 6: return !n; 7: return v; 8: return !v;
      9: return cy & !z; 10: return !cy | z; 11: return n == v; 12: return n != v;
      13: return !z & (n == v); 14: return z | (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic runOp(input logic [103:0] v, input string tag);
    logic [31:0] ins, base, off, offs, sum, addr;
    logic [3:0]  fl;
    int lag, op, lagLeft;
    bit legal, isReg, wb, post, pass, expReq, expIll, expFault, expDst, expBase;
    bit gotReq, doneSeen, holdOk;
    logic [31:0] reqAddr;
    {ins, fl, base, off} = v[103:4];
    lag = int'(v[3:0]);
    op = int'(ins[6:0]);
    legal = (op >= 1 && op <= 6);
    isReg = (op >= 4);
    wb    = legal && (op % 3 != 1);
    post  = (op == 3 || op == 6);
    offs  = isReg ? off : {{19{ins[31]}}, ins[31:21], 2'b00};
    sum   = base + offs;
    addr  = post ? base : sum;
    pass  = legal && refPred(ins[10:7], fl);
    expIll   = !legal;
    expReq   = pass && addr[1:0] == 0;
    expFault = (pass && addr[1:0] != 0) || (expReq && addr[31:28] == 4'hE);
    expDst   = expReq && !expFault;
    expBase  = expDst && wb && (ins[15:11] != ins[20:16]);

    instrI = ins; flagsI = fl; baseValI = base; offValI = off; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0; instrI = '0; baseValI = '0; offValI = '0;
    gotReq = 0; doneSeen = 0; holdOk = 1; lagLeft = lag; reqAddr = '0;
    for (int c = 0; c < 40 && !doneSeen; c++) begin
      if (done) begin
        doneSeen = 1;
        memRspValid = 1'b0;
      end else begin
        memRspValid = 1'b0;
        if (memReqValid && !memReqReady) begin
          if (gotReq && memReqAddr != reqAddr) holdOk = 0;
          reqAddr = memReqAddr;
          gotReq = 1;
          if (lagLeft == 0) memReqReady = 1'b1; else lagLeft--;
        end else if (memReqReady) begin
          memReqReady = 1'b0;
          memRspValid = 1'b1;
          memRspData  = memWord(reqAddr);
          memRspErr   = (reqAddr[31:28] == 4'hE);
        end
        @(negedge clk);
      end
    end
    chk(doneSeen, tag, "done seen", 32'(doneSeen), 1);
    chk(gotReq == expReq, "R1/R3/R10", {tag, " request issued"}, 32'(gotReq), 32'(expReq));
    if (expReq) begin
      chk(reqAddr == addr, "R6/R7/R8", {tag, " read address"}, reqAddr, addr);
      chk(holdOk, "R9", {tag, " request held"}, 32'(holdOk), 1);
    end
    chk(illegal == expIll, "R1", {tag, " illegal"}, 32'(illegal), 32'(expIll));
    chk(memFault == expFault, "R10/R11", {tag, " fault"}, 32'(memFault), 32'(expFault));
    chk(dstWrEn == expDst, "R6", {tag, " dst enable"}, 32'(dstWrEn), 32'(expDst));
    if (expDst) begin
      chk(dstWrIdx == ins[15:11], "R6", {tag, " dst index"}, 32'(dstWrIdx), 32'(ins[15:11]));
      chk(dstWrData == memWord(addr), "R6", {tag, " dst data"}, dstWrData, memWord(addr));
    end
    chk(baseWrEn == expBase, "R12", {tag, " base enable"}, 32'(baseWrEn), 32'(expBase));
    if (expBase) begin
      chk(baseWrIdx == ins[20:16], "R7", {tag, " base index"}, 32'(baseWrIdx), 32'(ins[20:16]));
      chk(baseWrData == sum, "R8", {tag, " base data"}, baseWrData, sum);
    end
    @(negedge clk);
    chk(!done, "R3", {tag, " done one cycle"}, 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!done && !memReqValid && !dstWrEn && !baseWrEn && !memFault && !illegal,
        "R13", "idle in reset", {26'b0, done, memReqValid, dstWrEn, baseWrEn, memFault, illegal}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memReqValid, "R13", "idle after reset", {30'b0, done, memReqValid}, 0);

    for (int i = 0; i < NV; i++) runOp(VEC[i], $sformatf("vec%0d", i));

    // R2 predicate sweep over every code and four flag patterns
    for (int cd = 0; cd < 16; cd++) begin
      for (int p = 0; p < 4; p++) begin
        logic [3:0] fl;
        fl = (p == 0) ? 4'b0000 : (p == 1) ? 4'b1010 : (p == 2) ? 4'b0101 : 4'b0110;
        runOp(mkv(1, cd, 3, 4, 0, fl, 32'h1000, 32'h0, 0), $sformatf("R2 cond%0d flags%b", cd, fl));
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule